// File: doc/BRIEF.md
# Byte Serial Peripheral Controller with Overflow and Mode-Fault Flags

This block moves one byte at a time over a four-wire SPI link and can act as the clock master or as a slave. A simple register interface controls it. A data write loads the transmit byte, and in master mode that write also starts the transfer. A data read strobe acknowledges the received byte. A control write sets enable, master select, clock polarity, clock phase and a two-bit rate code. A status read strobe arms the flag-clearing sequences.

In master mode the bit clock comes from a free-running prescaler. That prescaler runs only while the block is both enabled and master. Because of this, a transfer begins at the next internal bit boundary rather than at once. Two error flags protect the link:

- The overflow flag marks a byte that arrived while the previous one was still unread. That new byte is dropped.
- The mode-fault flag marks a slave-select input pulled active while the block is master. The block then drops out of master mode and releases its clock and data drivers.

Top module: `spi_err_ctrl`

## Requirements
- R1: The rate code r (0..3) selects a bit period of D = 2, 8, 32 or 128 bus cycles (D = 2·4^r). Each SCK half period lasts D/2 cycles. The prescaler runs only while enable and master are both set.
- R2: In master mode a data write is the only start command. The transfer starts at the next prescaler bit boundary, 0 to D−1 bus-clock edges after the edge that samples the write.
- R3: The SCK idle level equals the polarity bit, and SCK returns to it after the byte. With phase 1 the first SCK edge comes at the transfer start. With phase 0 it comes D/2 cycles after the start. Either way there are 8 sample edges per byte.
- R4: Data leaves MSB first on MOSI, changing only between sample edges. MISO is captured on each sample edge. After the byte, the received value appears on rx_data and rx_full sets.
- R5: rx_full clears only when a data-read strobe follows a status-read strobe. A data read on its own leaves it set.
- R6: A byte that completes while rx_full is set sets ovf_flag. That byte is discarded, and rx_data keeps the older byte.
- R7: ovf_flag clears on a status read followed by a data read. A data read on its own leaves it set.
- R8: In master mode, ss_n_in low sets modf_flag within 3 cycles. It also clears enable and master, and drops sck_oe and mosi_oe to 0.
- R9: modf_flag clears only on a status read followed by a control write. A control write on its own leaves it set.
- R10: As an enabled slave, the block never sets modf_flag, and sck_oe stays 0. miso_oe is 1 only while ss_n_in is low. The block shifts in MOSI and shifts out the last written byte MSB first on MISO, sampling on the rising edge when polarity equals phase and on the falling edge otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit written by ctl_wr |
| ctl_mstr | input | 1 | Master select bit |
| ctl_cpol | input | 1 | SCK idle level |
| ctl_cpha | input | 1 | Clock phase |
| ctl_rate | input | 2 | Rate code, divide 2·4^code |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rd | input | 1 | Data read strobe |
| sts_rd | input | 1 | Status read strobe |
| rx_data | output | 8 | Receive register |
| rx_full | output | 1 | Receive register holds an unread byte |
| ovf_flag | output | 1 | Overflow flag |
| modf_flag | output | 1 | Mode-fault flag |
| en_q | output | 1 | Current enable bit |
| mstr_q | output | 1 | Current master bit |
| sck_in | input | 1 | SCK from the pin (slave mode) |
| sck_out | output | 1 | SCK to the pin |
| sck_oe | output | 1 | SCK driver enable |
| mosi_in | input | 1 | MOSI from the pin (slave mode) |
| mosi_out | output | 1 | MOSI to the pin |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_in | input | 1 | MISO from the pin (master mode) |
| miso_out | output | 1 | MISO to the pin |
| miso_oe | output | 1 | MISO driver enable |
| ss_n_in | input | 1 | Slave-select input, active low |

## Verification
The bench counts negative clock edges after the edge that registers a data write. It expects the first SCK change within D−1 of them for phase 1, and between D/2 and D/2+D−1 for phase 0. rx_full and rx_data settle D/2 cycles after the eighth sample edge, so the bench reads them D/2+2 cycles after its model slave has taken the last MOSI bit. The mode fault passes two synchronizer stages and one flag register, so it is due 3 cycles after ss_n_in falls and is checked at the fourth. Slave-mode inputs are held 8 cycles per level, and MISO is read just before each rising SCK, well after the 3-cycle synchronizer path has settled.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
    localparam int RATE_W = 2;

    typedef struct packed {
        logic              en;
        logic              mstr;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
    } ctl_t;
endpackage

// File: rtl/spi_bitclk.sv
module spi_bitclk #(
    parameter int MAX_DIV = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick_half,
    output logic       tick_bit
);
    localparam int CW = $clog2(MAX_DIV);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   div_w, half_w;

    always_comb begin
        div_w     = (CW+1)'(MAX_DIV) >> {2'd3 - rate, 1'b0};
        half_w    = div_w >> 1;
        tick_bit  = run && ({1'b0, cnt_q} >= div_w - 1'b1);
        tick_half = tick_bit || (run && ({1'b0, cnt_q} == half_w - 1'b1));
        if (!run || tick_bit) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      st_q[i] <= RST;
            else if (i == 0) st_q[i] <= din;
            else             st_q[i] <= st_q[(i == 0) ? 0 : i-1];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/spi_err_ctrl.sv
module spi_err_ctrl
    import spi_err_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MAX_DIV = 128,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic              ctl_mstr,
    input  logic              ctl_cpol,
    input  logic              ctl_cpha,
    input  logic [RATE_W-1:0] ctl_rate,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              dat_rd,
    input  logic              sts_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              ovf_flag,
    output logic              modf_flag,
    output logic              en_q,
    output logic              mstr_q,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_n_in
);
    localparam int HW = $clog2(2*DATA_W);
    localparam int BW = $clog2(DATA_W);

    typedef struct packed {
        ctl_t              ctl;
        logic              pend;
        logic              busy;
        logic [HW-1:0]     hcnt;
        logic [DATA_W-1:0] sh;
        logic              rxbit;
        logic [DATA_W-1:0] rx;
        logic              rx_full;
        logic              ovf;
        logic              modf;
        logic              arm_rx;
        logic              arm_mf;
        logic              sck;
        logic [BW-1:0]     s_cnt;
        logic              sck_prev;
    } st_t;

    st_t  st_d, st_q;
    logic tick_half, tick_bit, done;
    logic is_mstr, is_slv;
    logic ss_s, sck_s, mosi_s;
    ctl_t ctl_in;

    assign is_mstr = st_q.ctl.en & st_q.ctl.mstr;
    assign is_slv  = st_q.ctl.en & ~st_q.ctl.mstr;
    assign ctl_in  = '{en: ctl_en, mstr: ctl_mstr, cpol: ctl_cpol,
                       cpha: ctl_cpha, rate: ctl_rate};

    spi_sync #(.W(3), .STAGES(SYNC_N), .RST(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_n_in, sck_in, mosi_in}),
        .dout ({ss_s, sck_s, mosi_s})
    );

    spi_bitclk #(.MAX_DIV(MAX_DIV)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (is_mstr),
        .rate     (st_q.ctl.rate),
        .tick_half(tick_half),
        .tick_bit (tick_bit)
    );

    always_comb begin
        st_d = st_q;
        done = 1'b0;

        // Register interface and flag-clearing sequences
        if (sts_rd) begin
            st_d.arm_rx = st_q.rx_full | st_q.ovf;
            st_d.arm_mf = st_q.modf;
        end
        if (dat_rd && st_q.arm_rx) begin
            st_d.rx_full = 1'b0;
            st_d.ovf     = 1'b0;
            st_d.arm_rx  = 1'b0;
        end
        if (ctl_wr) begin
            st_d.ctl = ctl_in;
            if (st_q.arm_mf) begin
                st_d.modf   = 1'b0;
                st_d.arm_mf = 1'b0;
            end
        end

        // Master engine: starts on a bit boundary, then walks 2*DATA_W half periods
        if (is_mstr) begin
            if (dat_wr && !st_q.busy) begin
                st_d.pend = 1'b1;
                st_d.sh   = dat_wdata;
            end
            if (!st_q.busy && tick_bit && (st_q.pend || dat_wr)) begin
                st_d.busy = 1'b1;
                st_d.hcnt = '0;
                st_d.pend = 1'b0;
            end else if (st_q.busy && tick_half) begin
                st_d.hcnt = st_q.hcnt + 1'b1;
                if (!st_q.hcnt[0]) begin
                    st_d.rxbit = miso_in;
                end else begin
                    st_d.sh = {st_q.sh[DATA_W-2:0], st_q.rxbit};
                    if (st_q.hcnt == HW'(2*DATA_W-1)) begin
                        st_d.busy = 1'b0;
                        done      = 1'b1;
                    end
                end
            end
        end

        // Slave engine: samples synchronized SCK edges
        if (is_slv) begin
            if (ss_s) begin
                st_d.s_cnt = '0;
                if (dat_wr) st_d.sh = dat_wdata;
            end else if (sck_s != st_q.sck_prev &&
                         sck_s == (st_q.ctl.cpol == st_q.ctl.cpha)) begin
                st_d.sh    = {st_q.sh[DATA_W-2:0], mosi_s};
                st_d.s_cnt = st_q.s_cnt + 1'b1;
                if (st_q.s_cnt == BW'(DATA_W-1)) begin
                    st_d.s_cnt = '0;
                    done       = 1'b1;
                end
            end
        end
        st_d.sck_prev = sck_s;

        // Receive register: an unread byte is kept, the new one is dropped
        if (done) begin
            if (st_d.rx_full) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.rx      = st_d.sh;
                st_d.rx_full = 1'b1;
            end
        end

        // Mode fault: another device pulls select low while this one is master
        if (is_mstr && !ss_s) begin
            st_d.modf     = 1'b1;
            st_d.ctl.en   = 1'b0;
            st_d.ctl.mstr = 1'b0;
        end
        if (!(st_d.ctl.en && st_d.ctl.mstr)) begin
            st_d.busy = 1'b0;
            st_d.pend = 1'b0;
        end

        st_d.sck = st_d.ctl.cpol ^ (st_d.busy & (st_d.hcnt[0] ^ st_d.ctl.cpha));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data   = st_q.rx;
    assign rx_full   = st_q.rx_full;
    assign ovf_flag  = st_q.ovf;
    assign modf_flag = st_q.modf;
    assign en_q      = st_q.ctl.en;
    assign mstr_q    = st_q.ctl.mstr;
    assign sck_out   = st_q.sck;
    assign sck_oe    = is_mstr;
    assign mosi_out  = st_q.sh[DATA_W-1];
    assign mosi_oe   = is_mstr;
    assign miso_out  = st_q.sh[DATA_W-1];
    assign miso_oe   = is_slv & ~ss_s;

    // R2/R3: in steady master mode SCK moves only on a prescaler half tick
    p_sck_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mstr && $past(is_mstr) && $stable(st_q.ctl.cpol) &&
         $stable(st_q.ctl.cpha) && !$stable(st_q.sck)) |-> $past(tick_half));

    // R4: the receive register fills only at the end of a byte
    p_full_by_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rx_full) |-> $past(done));

    // R6: the byte raising overflow does not replace the stored one
    p_ovf_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> $stable(st_q.rx));

    // R8: a mode fault leaves master mode with the drivers released
    p_modf_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.modf) |-> (!sck_oe && !mosi_oe && !st_q.ctl.mstr && !st_q.ctl.en));

    // R9: mode fault clears only by a control write after a status read
    p_modf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.modf) |-> ($past(ctl_wr) && $past(st_q.arm_mf)));
endmodule

// File: tb/sim_spi_err_ctrl.sv
module sim_spi_err_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       ctl_wr = 0, ctl_en = 0, ctl_mstr = 0, ctl_cpol = 0, ctl_cpha = 0;
    logic [1:0] ctl_rate = 0;
    logic       dat_wr = 0, dat_rd = 0, sts_rd = 0;
    logic [7:0] dat_wdata = 0;
    logic [7:0] rx_data;
    logic       rx_full, ovf_flag, modf_flag, en_q, mstr_q;
    logic       sck_in = 0, mosi_in = 0, miso_in = 0, ss_n_in = 1;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

    spi_err_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_mstr(ctl_mstr),
        .ctl_cpol(ctl_cpol), .ctl_cpha(ctl_cpha), .ctl_rate(ctl_rate),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .sts_rd(sts_rd),
        .rx_data(rx_data), .rx_full(rx_full), .ovf_flag(ovf_flag),
        .modf_flag(modf_flag), .en_q(en_q), .mstr_q(mstr_q),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_n_in(ss_n_in)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    bit         mon_on = 0;
    int         mon_n = 0;
    logic [7:0] mon_sh = 0;
    logic [7:0] mpat = 0;
    logic       cfg_cpol = 0, cfg_cpha = 0;
    time        t_first = 0, t_last = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: model slave on the master's pins; pops expected MOSI bytes
    always @(sck_out) begin
        if (mon_on && ((sck_out != cfg_cpol) == !cfg_cpha)) begin
            if (mon_n == 0) t_first = $time;
            t_last = $time;
            mon_sh = {mon_sh[6:0], mosi_out};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) check("R4 unexpected byte on MOSI", 1, 0);
                else check("R4 MOSI byte MSB first", {24'd0, mon_sh}, {24'd0, exp_q.pop_front()});
            end else begin
                #1 miso_in = mpat[7-mon_n];
            end
        end
    end

    task automatic set_ctl(input logic en, input logic mstr, input logic cpol,
                           input logic cpha, input logic [1:0] rate);
        @(negedge clk);
        ctl_en = en; ctl_mstr = mstr; ctl_cpol = cpol; ctl_cpha = cpha; ctl_rate = rate;
        ctl_wr = 1; cfg_cpol = cpol; cfg_cpha = cpha;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic read_sts();
        @(negedge clk); sts_rd = 1;
        @(negedge clk); sts_rd = 0;
    endtask

    task automatic read_dat();
        @(negedge clk); dat_rd = 1;
        @(negedge clk); dat_rd = 0;
    endtask

    // Driver: pushes the expected MOSI byte, starts a master transfer, checks timing
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] pat, input int div);
        int   n;
        logic idle;
        idle = cfg_cpol;
        exp_q.push_back(tx);
        mpat = pat; mon_n = 0; miso_in = pat[7]; mon_on = 1;
        @(negedge clk); dat_wdata = tx; dat_wr = 1;
        @(negedge clk); dat_wr = 0;
        n = 0;
        while (sck_out === idle && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (cfg_cpha) check("R2 start delay, phase 1", {31'd0, n <= div - 1}, 1);
        else check("R3 first edge delay, phase 0",
                   {31'd0, (n >= div/2) && (n <= div/2 + div - 1)}, 1);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (div/2 + 2) @(negedge clk);
        mon_on = 0;
        check("R1 bit period from sample edges", 32'(t_last - t_first), 32'(7 * div * 8));
        check("R3 SCK back at idle level", {31'd0, sck_out}, {31'd0, idle});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R4 reset rx_full", {31'd0, rx_full}, 0);
        check("R6 reset ovf", {31'd0, ovf_flag}, 0);
        check("R8 reset modf and sck_oe", {30'd0, modf_flag, sck_oe}, 0);

        // R1/R2/R4/R5: every rate, phase 1, polarity 0, varied write timing
        for (int r = 0; r < 4; r++) begin
            set_ctl(1, 1, 0, 1, 2'(r));
            repeat (r * 5 + 3) @(negedge clk);
            master_xfer(8'h96 ^ 8'(r), 8'h3C + 8'(r * 17), 2 << (2 * r));
            check("R4 rx_data after master byte", {24'd0, rx_data}, {24'd0, 8'h3C + 8'(r * 17)});
            check("R4 rx_full set", {31'd0, rx_full}, 1);
            read_sts();
            read_dat();
            check("R5 rx_full cleared by status then data read", {31'd0, rx_full}, 0);
        end

        // R3: phase 0 with both polarities, phase 1 with polarity 1
        set_ctl(1, 1, 0, 0, 2'd1);
        repeat (2) @(negedge clk);
        master_xfer(8'hE1, 8'h7B, 8);
        check("R4 rx_data phase 0", {24'd0, rx_data}, 32'h7B);
        read_sts(); read_dat();

        set_ctl(1, 1, 1, 0, 2'd0);
        repeat (2) @(negedge clk);
        check("R3 idle level follows polarity", {31'd0, sck_out}, 1);
        master_xfer(8'h0F, 8'h81, 2);
        read_sts(); read_dat();

        set_ctl(1, 1, 1, 1, 2'd2);
        repeat (7) @(negedge clk);
        master_xfer(8'h5C, 8'hA6, 32);
        check("R4 rx_data polarity 1 phase 1", {24'd0, rx_data}, 32'hA6);
        read_sts(); read_dat();

        // R5/R6/R7: overflow keeps the unread byte
        set_ctl(1, 1, 0, 1, 2'd0);
        master_xfer(8'h11, 8'h5A, 2);
        read_dat();
        check("R5 data read alone leaves rx_full", {31'd0, rx_full}, 1);
        master_xfer(8'h22, 8'hC3, 2);
        check("R6 overflow flag set", {31'd0, ovf_flag}, 1);
        check("R6 old byte retained", {24'd0, rx_data}, 32'h5A);
        read_dat();
        check("R7 data read alone leaves ovf", {31'd0, ovf_flag}, 1);
        read_sts(); read_dat();
        check("R7 ovf cleared by status then data read", {31'd0, ovf_flag}, 0);
        check("R5 rx_full cleared with ovf", {31'd0, rx_full}, 0);

        // R8/R9: mode fault in master mode
        ss_n_in = 0;
        repeat (4) @(negedge clk);
        check("R8 modf set", {31'd0, modf_flag}, 1);
        check("R8 drivers released", {30'd0, sck_oe, mosi_oe}, 0);
        check("R8 enable and master cleared", {30'd0, en_q, mstr_q}, 0);
        ss_n_in = 1;
        repeat (4) @(negedge clk);
        set_ctl(1, 0, 0, 0, 2'd0);
        check("R9 control write alone leaves modf", {31'd0, modf_flag}, 1);
        read_sts();
        set_ctl(1, 0, 0, 0, 2'd0);
        check("R9 modf cleared by status then control write", {31'd0, modf_flag}, 0);

        // R10: slave mode, polarity 0 phase 0, sample on rising SCK
        check("R10 slave sck_oe low", {31'd0, sck_oe}, 0);
        check("R10 miso_oe low while deselected", {31'd0, miso_oe}, 0);
        @(negedge clk); dat_wdata = 8'hA5; dat_wr = 1;
        @(negedge clk); dat_wr = 0;
        ss_n_in = 0;
        repeat (4) @(negedge clk);
        check("R10 miso_oe high while selected", {31'd0, miso_oe}, 1);
        check("R10 no mode fault as slave", {31'd0, modf_flag}, 0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] sdat;
            logic [7:0] stx;
            sdat = 8'h3C;
            stx  = 8'hA5;
            mosi_in = sdat[7-i];
            repeat (8) @(negedge clk);
            check("R10 slave MISO bit", {31'd0, miso_out}, {31'd0, stx[7-i]});
            sck_in = 1;
            repeat (8) @(negedge clk);
            sck_in = 0;
        end
        repeat (6) @(negedge clk);
        check("R10 slave rx_data", {24'd0, rx_data}, 32'h3C);
        check("R10 slave rx_full", {31'd0, rx_full}, 1);
        ss_n_in = 1;
        repeat (4) @(negedge clk);
        check("R10 miso_oe released", {31'd0, miso_oe}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule